// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an 8-line general-purpose I/O port that sits on a simple byte-wide register bus with single-cycle reads and writes. Each line can be set as an input or an output through a direction register. Output lines drive a pad output value and a pad output-enable. Input lines are sampled through a two-flop synchronizer before any read can see them.

Values go in and out through a data window. In that window the address itself carries a per-line mask: address bit n+2 selects line n. A write can set or clear any subset of lines without first reading the register. This lets separate software agents own separate lines and update them atomically. A read through the window returns only the selected lines and zeros elsewhere. A data write has no effect on any line that is currently an input.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every line is an input: `pad_oe` is 0x00, `pad_out` is 0x00, and a read of the direction register at 0x400 returns 0x00.
- R2: A write to the exact byte address 0x400 loads the direction register, where bit n at 1 makes line n an output. A read of 0x400 returns the stored value. `pad_oe` bit n follows direction bit n from the clock edge of the write.
- R3: A write at an address below 0x400 changes the output data bit of line n only when address bit n+2 is 1. Every other output data bit keeps its value.
- R4: A data write leaves the stored output bit of a line unchanged while that line's direction bit is 0. The ignored value does not appear when the line is later made an output.
- R5: A read at an address below 0x400 returns 0 in bit n whenever address bit n+2 is 0.
- R6: For a selected input line, a data read returns `pad_in` after two register stages. A pad change made between edges is visible after the second rising edge, and not after the first.
- R7: For a selected output line, a data read returns the stored output value, whatever the level on `pad_in`.
- R8: At any address above 0x400, including 0x401 to 0x403, a read returns 0x00 and a write changes neither the direction nor the output data.
- R9: `pad_out` bit n equals the stored output data bit n at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as a read access |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The hardest case to reach is a line that received a data write while it was an input and then became an output. The stored bit must still hold its value from before that write. To reach it, the stimulus first drives known output values with all lines as outputs. It then turns half the lines into inputs, writes all ones through a full mask, and finally switches every line back to output so that the untouched register bits show on `pad_out`. The synchronizer latency is measured by changing `pad_in` between edges and reading once after one edge and again after two.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // Kind of register a bus address resolves to
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2
   } acc_kind_e;

   // Decoded bus strobes handed to the line slices
   typedef struct packed {
      logic data_wr;
      logic dir_wr;
   } wr_strobe_t;

endpackage : gpio_mask_pkg

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_mask_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int LINES      = 8,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output acc_kind_e         kind,
   output wr_strobe_t        strobe,
   output logic [LINES-1:0]  lane_mask
);

   localparam int                MASK_LSB = 2;
   localparam int                MASK_MSB = MASK_LSB + LINES - 1;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic in_window;
   logic dir_hit;

   assign in_window = (bus_addr < DIR_ADDR);
   assign dir_hit   = (bus_addr == DIR_ADDR);
   assign lane_mask = bus_addr[MASK_MSB:MASK_LSB];

   always_comb begin
      if (in_window)    kind = ACC_DATA;
      else if (dir_hit) kind = ACC_DIR;
      else              kind = ACC_NONE;
   end

   always_comb begin
      strobe.data_wr = bus_sel && bus_write && (kind == ACC_DATA);
      strobe.dir_wr  = bus_sel && bus_write && (kind == ACC_DIR);
   end

endmodule : gpio_addr_decode

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d;
         end
         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule : gpio_sync_chain

// File: rtl/gpio_line_slice.sv
module gpio_line_slice
   import gpio_mask_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wr_strobe_t strobe,
   input  logic       lane_sel,
   input  logic       wbit,
   input  logic       pad_sync,
   output logic       dir_q,
   output logic       out_q,
   output logic       rd_bit
);

   // Direction bit: 1 = output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           dir_q <= 1'b0;
      else if (strobe.dir_wr) dir_q <= wbit;
   end

   // Output bit updates only when the lane is selected and already an output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= 1'b0;
      else if (strobe.data_wr && lane_sel && dir_q)
         out_q <= wbit;
   end

   assign rd_bit = dir_q ? out_q : pad_sync;

endmodule : gpio_line_slice

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int LINES       = 8,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 12,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe
);

   localparam int WINDOW_SPAN = 1 << (LINES + 2);

   // Elaboration-time parameter checks
   generate
      if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
         $error("gpio_mask_port: LINES must be 1..BUS_W");
      end
      if (DIR_OFFSET < WINDOW_SPAN) begin : g_bad_window
         $error("gpio_mask_port: DIR_OFFSET overlaps the mask window");
      end
      if (DIR_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_mask_port: DIR_OFFSET does not fit ADDR_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("gpio_mask_port: SYNC_STAGES must be at least 1");
      end
   endgenerate

   acc_kind_e        kind;
   wr_strobe_t       strobe;
   logic [LINES-1:0] lane_mask;
   logic [LINES-1:0] pad_sync;
   logic [LINES-1:0] dir_q;
   logic [LINES-1:0] out_q;
   logic [LINES-1:0] rd_bits;
   logic [LINES-1:0] wlines;

   assign wlines = bus_wdata[LINES-1:0];

   gpio_addr_decode #(
      .ADDR_W     (ADDR_W),
      .LINES      (LINES),
      .DIR_OFFSET (DIR_OFFSET)
   ) i_decode (
      .bus_sel   (bus_sel),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .kind      (kind),
      .strobe    (strobe),
      .lane_mask (lane_mask)
   );

   gpio_sync_chain #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   generate
      for (genvar n = 0; n < LINES; n++) begin : g_line
         gpio_line_slice i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (strobe),
            .lane_sel (lane_mask[n]),
            .wbit     (wlines[n]),
            .pad_sync (pad_sync[n]),
            .dir_q    (dir_q[n]),
            .out_q    (out_q[n]),
            .rd_bit   (rd_bits[n])
         );
      end
   endgenerate

   assign pad_out = out_q;
   assign pad_oe  = dir_q;

   // Read return path; unmapped and unselected bits read zero
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_write) begin
         unique case (kind)
            ACC_DATA: bus_rdata[LINES-1:0] = rd_bits & lane_mask;
            ACC_DIR:  bus_rdata[LINES-1:0] = dir_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule : gpio_mask_port

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int LINES      = 8,
   parameter int BUS_W      = 8,
   parameter int ADDR_W     = 12,
   parameter int DIR_OFFSET = 'h400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [LINES-1:0]  pad_out,
   input logic [LINES-1:0]  pad_oe
);

   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic             win_acc;
   logic             dir_acc;
   logic [LINES-1:0] sel_mask;

   assign win_acc  = bus_sel && (bus_addr < DIR_ADDR);
   assign dir_acc  = bus_sel && (bus_addr == DIR_ADDR);
   assign sel_mask = bus_addr[LINES+1:2];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0));

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dir_acc && bus_write) |=> $stable(pad_oe));

   // R3
   unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && bus_write) |=> ((pad_out ^ $past(pad_out)) & ~$past(sel_mask)) == '0);

   // R4
   input_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && bus_write) |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

   // R5
   read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && !bus_write) |-> (bus_rdata[LINES-1:0] & ~sel_mask) == '0);

   // R8
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_write && !win_acc && !dir_acc) |-> bus_rdata == '0);

   // R8
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_write && !win_acc && !dir_acc) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule : gpio_mask_port_chk

bind gpio_mask_port gpio_mask_port_chk #(
   .LINES      (LINES),
   .BUS_W      (BUS_W),
   .ADDR_W     (ADDR_W),
   .DIR_OFFSET (DIR_OFFSET)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;

   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] DIR_A = 12'h400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mask_port i_gpio_mask_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   function automatic logic [11:0] mask_addr(input logic [7:0] m);
      return {2'b00, m, 2'b00};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      bus_rd(DIR_A, v);
      check("R1 dir read", v, 8'h00);
   endtask

   task automatic t_direction;
      logic [7:0] v;
      bus_wr(DIR_A, 8'hA5);
      bus_rd(DIR_A, v);
      check("R2 dir readback", v, 8'hA5);
      check("R2 pad_oe", pad_oe, 8'hA5);
   endtask

   task automatic t_masked_write;
      bus_wr(DIR_A, 8'hFF);
      bus_wr(mask_addr(8'hFF), 8'h00);
      check("R9 cleared", pad_out, 8'h00);
      bus_wr(mask_addr(8'h09), 8'hFF);
      check("R3 lines 0,3 set", pad_out, 8'h09);
      bus_wr(mask_addr(8'hF0), 8'hA5);
      check("R3 high nibble", pad_out, 8'hA9);
      bus_wr(mask_addr(8'h08), 8'h00);
      check("R9 single clear", pad_out, 8'hA1);
      bus_wr(mask_addr(8'h08), 8'hFF);
      check("R3 single set", pad_out, 8'hA9);
   endtask

   task automatic t_input_ignored;
      bus_wr(DIR_A, 8'h0F);
      bus_wr(mask_addr(8'hFF), 8'hFF);
      check("R4 inputs untouched", pad_out, 8'hAF);
      bus_wr(DIR_A, 8'hFF);
      check("R4 after turn to output", pad_out, 8'hAF);
   endtask

   task automatic t_masked_read;
      logic [7:0] v;
      bus_rd(mask_addr(8'h0C), v);
      check("R5 mask 0C", v, 8'h0C);
      bus_rd(mask_addr(8'h50), v);
      check("R5 mask 50", v, 8'h00);
      bus_rd(mask_addr(8'h81), v);
      check("R5 mask 81", v, 8'h81);
   endtask

   task automatic t_sync_and_mixed;
      logic [7:0] v;
      bus_wr(DIR_A, 8'h00);
      @(negedge clk); pad_in = 8'h00;
      repeat (3) @(negedge clk);
      @(negedge clk); pad_in = 8'h3C;
      bus_rd(mask_addr(8'hFF), v);
      check("R6 after one edge", v, 8'h00);
      bus_rd(mask_addr(8'hFF), v);
      check("R6 after two edges", v, 8'h3C);
      bus_wr(DIR_A, 8'hF0);
      @(negedge clk); pad_in = 8'h5F;
      repeat (3) @(negedge clk);
      bus_rd(mask_addr(8'hFF), v);
      check("R7 outputs ignore pad", v, 8'hAF);
      bus_rd(mask_addr(8'h30), v);
      check("R7 masked output read", v, 8'h20);
   endtask

   task automatic t_unmapped;
      logic [7:0] v;
      bus_wr(DIR_A, 8'hFF);
      bus_wr(12'h404, 8'h00);
      bus_wr(12'h401, 8'h00);
      bus_wr(12'h800, 8'h00);
      check("R8 pad_oe kept", pad_oe, 8'hFF);
      check("R8 pad_out kept", pad_out, 8'hAF);
      bus_rd(12'h404, v);
      check("R8 read 404", v, 8'h00);
      bus_rd(12'h401, v);
      check("R8 read 401", v, 8'h00);
      bus_rd(12'hFFC, v);
      check("R8 read FFC", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direction();
      t_masked_write();
      t_input_ignored();
      t_masked_read();
      t_sync_and_mixed();
      t_unmapped();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: R1..suite not finished, actual=running expected=done");
         report();
      end
   end

endmodule : test_gpio_mask_port